// File: doc/BRIEF.md
# Host Port Slave with Ready Handshake

This block lets an external 16-bit host reach a 32-bit internal memory space through three registers: a control word, an address pointer and a data word. Each 32-bit register is moved as two half-word transfers. A transfer is framed by a composite strobe. The strobe is active when chip select is low and exactly one of the two data strobes is low. Register select, read/write and half select are latched either when an optional address strobe falls or, if that strobe stayed idle, when the composite strobe falls.

Host pins pass through a synchronizer into the internal clock domain, and every edge is detected there. Traffic to the data register becomes 32-bit requests on an internal memory port that uses a request/acknowledge handshake. An active-high busy/ready output tells the host when to hold its strobe. It is busy while a data read fetches its word, and busy again after a data write or an autoincrement read while the memory finishes. The read bus is driven only during read strobes, shown as a data output with a separate output enable.

Top module: `host_port_slave`

## Requirements
- R1: The composite strobe is active only when chip select is low and data strobes one and two differ. With both data strobes low, no register changes.
- R2: When the address strobe has not fallen since the last access, register select (2 bits), read/write (1 = read) and half select (0 = low half, 1 = high half) are taken at the falling edge of the composite strobe.
- R3: A falling address strobe captures the select fields. Select changes made after it and before the composite strobe are ignored by that access.
- R4: After reset the ready output is 0, no memory request is pending and the data bus is not driven.
- R5: While chip select is high the ready output is 0, even while a memory transaction is still running.
- R6: A read of the low half of the data register (select 10 or 11) issues a memory read at the address register. Ready stays 1 until the word is loaded, and the host then sees its low half.
- R7: Host write data is taken at the rising strobe edge. A data write of the low half only stores it. The high half completes the word and issues one 32-bit memory write, and ready is 1 until it is acknowledged.
- R8: Select 00 (control) and 01 (address) are plain 32-bit read/write registers, and accessing them never drives ready to 1.
- R9: Select 10 adds 4 to the address after each completed 32-bit data write, and at the end of each high-half data read. Select 11 leaves the address unchanged.
- R10: After a high-half read with select 10, the block prefetches the word at the new address with ready at 1. The next low-half data read is then served from that word without a fetch and without ready rising.
- R11: The data output enable is 1 only while a read strobe is active.
- R12: A memory request stays high until acknowledged and drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_ds1_n | input | 1 | Host data strobe one |
| hp_ds2_n | input | 1 | Host data strobe two |
| hp_as_n | input | 1 | Optional address strobe, active low; tie high if unused |
| hp_sel | input | 2 | Register select: 00 control, 01 address, 10 data autoincrement, 11 data fixed |
| hp_rnw | input | 1 | 1 = read, 0 = write |
| hp_half | input | 1 | 0 = low half, 1 = high half |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data |
| hp_doe | output | 1 | Read data output enable |
| hp_rdy | output | 1 | Busy indication, 1 = hold strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word |
| mem_ack | input | 1 | Memory acknowledge pulse |

## Verification
The main path is driven in four patterns. Control/address round trips show that those registers stay apart from the ready logic. Fixed-address data writes and reads show when ready rises, with the memory latency long enough to see it. Autoincrement sequences tell a fetched read apart from a prefetched one, both by whether ready rises and by the address read back. Strobe variants cover data strobe two alone, both data strobes low, and an address-strobe latch followed by scrambled selects, which separates the two latching paths.

// File: rtl/host_port_slave.sv
module host_port_slave #(
  parameter int HW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hp_cs_n,
  input  logic          hp_ds1_n,
  input  logic          hp_ds2_n,
  input  logic          hp_as_n,
  input  logic [1:0]    hp_sel,
  input  logic          hp_rnw,
  input  logic          hp_half,
  input  logic [HW-1:0] hp_din,
  output logic [HW-1:0] hp_dout,
  output logic          hp_doe,
  output logic          hp_rdy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [2*HW-1:0] mem_addr,
  output logic [2*HW-1:0] mem_wdata,
  input  logic [2*HW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int DW   = 2 * HW;
  localparam int W    = HW + 8;
  localparam int STEP = DW / 8;
  localparam logic [W-1:0] SRST = {4'b1111, {(W-4){1'b0}}};

  logic [W-1:0] sq [SYNC];
  logic [W-1:0] s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sq[i] <= SRST;
    end else begin
      sq[0] <= {hp_cs_n, hp_ds1_n, hp_ds2_n, hp_as_n, hp_sel, hp_rnw, hp_half, hp_din};
      for (int i = 1; i < SYNC; i++) sq[i] <= sq[i-1];
    end
  end

  assign s = sq[SYNC-1];

  logic          cs_s, ds1_s, ds2_s, as_s, rnw_s, half_s;
  logic [1:0]    sel_s;
  logic [HW-1:0] din_s;
  assign cs_s   = s[W-1];
  assign ds1_s  = s[W-2];
  assign ds2_s  = s[W-3];
  assign as_s   = s[W-4];
  assign sel_s  = s[W-5:W-6];
  assign rnw_s  = s[W-7];
  assign half_s = s[W-8];
  assign din_s  = s[HW-1:0];

  logic stb_n, stb_q, as_q;
  logic stb_fall, stb_rise, as_fall;
  assign stb_n    = ~(ds1_s ^ ds2_s) | cs_s;
  assign stb_fall = stb_q & ~stb_n;
  assign stb_rise = ~stb_q & stb_n;
  assign as_fall  = as_q & ~as_s;

  logic       as_seen;
  logic [1:0] a_sel;
  logic       a_rnw, a_half;
  logic [1:0] f_sel;
  logic       f_rnw, f_half;
  assign f_sel  = as_seen ? a_sel  : sel_s;
  assign f_rnw  = as_seen ? a_rnw  : rnw_s;
  assign f_half = as_seen ? a_half : half_s;

  logic [DW-1:0] ctl_r, adr_r, dat_r;
  logic busy, active, pf_valid, pf_pend, inc_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b1;
      as_q     <= 1'b1;
      as_seen  <= 1'b0;
      a_sel    <= 2'b00;
      a_rnw    <= 1'b0;
      a_half   <= 1'b0;
      active   <= 1'b0;
      ctl_r    <= '0;
      adr_r    <= '0;
      dat_r    <= '0;
      busy     <= 1'b0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      pf_valid <= 1'b0;
      pf_pend  <= 1'b0;
      inc_pend <= 1'b0;
    end else begin
      stb_q <= stb_n;
      as_q  <= as_s;

      if (as_fall) begin
        as_seen <= 1'b1;
        a_sel   <= sel_s;
        a_rnw   <= rnw_s;
        a_half  <= half_s;
      end

      if (stb_fall) begin
        active <= 1'b1;
        a_sel  <= f_sel;
        a_rnw  <= f_rnw;
        a_half <= f_half;
        if (f_sel[1] && f_rnw && !f_half) begin
          if (pf_valid) begin
            pf_valid <= 1'b0;
          end else if (!busy) begin
            mem_req <= 1'b1;
            mem_we  <= 1'b0;
            busy    <= 1'b1;
          end
        end
      end

      if (stb_rise) begin
        active  <= 1'b0;
        as_seen <= 1'b0;
        if (!a_rnw) begin
          case (a_sel)
            2'b00: if (a_half) ctl_r[DW-1:HW] <= din_s; else ctl_r[HW-1:0] <= din_s;
            2'b01: begin
              if (a_half) adr_r[DW-1:HW] <= din_s; else adr_r[HW-1:0] <= din_s;
              pf_valid <= 1'b0;
            end
            default: begin
              if (a_half) dat_r[DW-1:HW] <= din_s; else dat_r[HW-1:0] <= din_s;
              pf_valid <= 1'b0;
              if (a_half) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b1;
                busy     <= 1'b1;
                inc_pend <= (a_sel == 2'b10);
              end
            end
          endcase
        end else if (a_sel == 2'b10 && a_half) begin
          adr_r    <= adr_r + DW'(STEP);
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          busy     <= 1'b1;
          pf_pend  <= 1'b1;
          pf_valid <= 1'b0;
        end
      end

      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        busy    <= 1'b0;
        if (!mem_we) begin
          dat_r <= mem_rdata;
          if (pf_pend) pf_valid <= 1'b1;
          pf_pend <= 1'b0;
        end else if (inc_pend) begin
          adr_r    <= adr_r + DW'(STEP);
          inc_pend <= 1'b0;
        end
      end
    end
  end

  logic [DW-1:0] rd_word;
  always_comb begin
    case (a_sel)
      2'b00:   rd_word = ctl_r;
      2'b01:   rd_word = adr_r;
      default: rd_word = dat_r;
    endcase
  end

  assign hp_dout   = a_half ? rd_word[DW-1:HW] : rd_word[HW-1:0];
  assign hp_doe    = active & a_rnw;
  assign hp_rdy    = busy & ~cs_s;
  assign mem_addr  = adr_r;
  assign mem_wdata = dat_r;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);
  p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
  p_wr_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && mem_we |-> a_half && !a_rnw);
  p_reg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall && !f_sel[1] && !busy |=> !busy);
  p_busy_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req);
  p_fixed_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we && !inc_pend |=> adr_r == $past(adr_r));
  p_doe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hp_doe |-> !stb_q);
endmodule

// File: tb/host_port_slave_test.sv
module host_port_slave_test;
  localparam int PERIOD = 10;
  localparam int LAT    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ds1_n = 1'b1, ds2_n = 1'b1, as_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic rnw = 1'b0, half = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic doe, rdy, req, we, ack;
  logic [31:0] addr, wdata, rdata;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  host_port_slave uut (
    .clk(clk), .rst_n(rst_n),
    .hp_cs_n(cs_n), .hp_ds1_n(ds1_n), .hp_ds2_n(ds2_n), .hp_as_n(as_n),
    .hp_sel(sel), .hp_rnw(rnw), .hp_half(half), .hp_din(din),
    .hp_dout(dout), .hp_doe(doe), .hp_rdy(rdy),
    .mem_req(req), .mem_we(we), .mem_addr(addr), .mem_wdata(wdata),
    .mem_rdata(rdata), .mem_ack(ack)
  );

  logic [31:0] mem [64];
  int lcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; lcnt <= 0; rdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else if (req && !ack) begin
      if (lcnt == LAT - 1) begin
        ack  <= 1'b1;
        lcnt <= 0;
        if (we) mem[addr[7:2]] <= wdata;
        rdata <= mem[addr[7:2]];
      end else lcnt <= lcnt + 1;
    end else ack <= 1'b0;
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  // mode: 0 = strobe via ds1, 1 = via ds2, 2 = both ds low (no strobe)
  task automatic access(input logic [1:0] s, input logic r, input logic h, input logic [15:0] wd,
                        input logic [15:0] exp, input bit pre, input bit post,
                        input int mode, input bit use_as, input string rq);
    @(negedge clk);
    sel = s; rnw = r; half = h; din = wd;
    if (use_as) begin
      repeat (3) @(negedge clk);
      as_n = 1'b0;
      repeat (4) @(negedge clk);
      sel = ~s; half = ~h;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    if (mode == 0) ds1_n = 1'b0;
    else if (mode == 1) ds2_n = 1'b0;
    else begin ds1_n = 1'b0; ds2_n = 1'b0; end
    repeat (4) @(negedge clk);
    if (mode != 2) begin
      check(rdy == pre, rq, 32'(rdy), 32'(pre));
      check(doe == r, "R11", 32'(doe), 32'(r));
      for (int k = 0; k < 100 && rdy; k++) @(negedge clk);
      if (r) check(dout == exp, rq, 32'(dout), 32'(exp));
    end
    as_n = 1'b1;
    ds1_n = 1'b1; ds2_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rdy == post, rq, 32'(rdy), 32'(post));
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy == 1'b0, "R5", 32'(rdy), 32'h0);
    repeat (30) @(negedge clk);
    check(doe == 1'b0, "R11", 32'(doe), 32'h0);
  endtask

  // {post_busy, pre_busy, sel, rnw, half, wdata, expected}; R2 readback of latched selects
  localparam logic [37:0] VEC [14] = '{
    {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'hA5A5, 16'h0000},
    {1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 16'h5A5A, 16'h0000},
    {1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 16'h0000, 16'hA5A5},
    {1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 16'h0000, 16'h5A5A},
    {1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 16'h0010, 16'h0000},
    {1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 16'h5678, 16'h0000},
    {1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0010},
    {1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 16'h0000, 16'h5678},
    {1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 16'hBEEF, 16'h0000},
    {1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 16'hDEAD, 16'h0000},
    {1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0014}
  };

  bit done = 1'b0;

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy == 1'b0, "R4", 32'(rdy), 32'h0);
    check(req == 1'b0, "R4", 32'(req), 32'h0);
    check(doe == 1'b0, "R4", 32'(doe), 32'h0);

    for (int v = 0; v < 14; v++) begin
      logic [37:0] e;
      string rq;
      e = VEC[v];
      rq = !e[35] ? "R2 R8" : (e[33] ? "R6" : "R7");
      access(e[35:34], e[33], e[32], e[31:16], e[15:0], e[36], e[37], 0, 1'b0, rq);
    end
    check(mem[4] == 32'hDEADBEEF, "R7", mem[4], 32'hDEADBEEF);

    // autoincrement writes then fetch/prefetch reads
    access(2'b01, 0, 0, 16'h0020, 0, 0, 0, 0, 0, "R8");
    access(2'b10, 0, 0, 16'h2222, 0, 0, 0, 0, 0, "R7");
    access(2'b10, 0, 1, 16'h1111, 0, 0, 1, 0, 0, "R7");
    access(2'b10, 0, 0, 16'h4444, 0, 0, 0, 0, 0, "R7");
    access(2'b10, 0, 1, 16'h3333, 0, 0, 1, 0, 0, "R7");
    check(mem[8] == 32'h11112222, "R9", mem[8], 32'h11112222);
    check(mem[9] == 32'h33334444, "R9", mem[9], 32'h33334444);
    access(2'b01, 1, 0, 0, 16'h0028, 0, 0, 0, 0, "R9");
    access(2'b01, 0, 0, 16'h0020, 0, 0, 0, 0, 0, "R8");
    access(2'b10, 1, 0, 0, 16'h2222, 1, 0, 0, 0, "R6");
    access(2'b10, 1, 1, 0, 16'h1111, 0, 1, 0, 0, "R10");
    access(2'b01, 1, 0, 0, 16'h0024, 0, 0, 0, 0, "R9");
    access(2'b10, 1, 0, 0, 16'h4444, 0, 0, 0, 0, "R10");
    access(2'b10, 1, 1, 0, 16'h3333, 0, 1, 0, 0, "R10");

    // strobe decode: ds2 alone works, both low is no access
    access(2'b01, 0, 0, 16'h0030, 0, 0, 0, 1, 0, "R1");
    access(2'b01, 0, 0, 16'h0077, 0, 0, 0, 2, 0, "R1");
    access(2'b01, 1, 0, 0, 16'h0030, 0, 0, 0, 0, "R1");

    // address strobe latch, then selects scrambled before strobe
    access(2'b01, 0, 0, 16'h0044, 0, 0, 0, 0, 1, "R3");
    access(2'b01, 1, 0, 0, 16'h0044, 0, 0, 0, 0, "R3");
    access(2'b00, 1, 1, 0, 16'h5A5A, 0, 0, 0, 0, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule